// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the stored contents of a function's six base address registers and its expansion-ROM base register into decoded address windows. For every region it takes the register value, the region's power-of-two size (zero meaning the region is not implemented) and whether the region claims I/O or memory space. Together with the I/O-enable and memory-enable bits of the function's command register, it produces a valid flag and a size-aligned base address for each region.

Some windows are never handed on as mapped. A base of zero, a window whose last address does not lie above its base, an I/O window reaching past the 64 KiB port space, a memory window ending at the all-ones address, and an expansion ROM whose enable bit is clear all decode as unmapped. The decoded windows are registered. A per-region change pulse tells a downstream mapper that a window has to be torn down or set up again. Claiming transactions and performing the mapping are left to other blocks.

Region indices 0 to 5 are the base registers, which sit at configuration offsets 0x10 + 4·n. Region index 6 is the expansion ROM, which sits at offset 0x30.

Top module: `bar_window_decoder`

## Requirements
- R1: A region whose size input is zero never reports a valid window.
- R2: A region typed I/O (type bit = 1) is valid only while command enable bit 0 is set. A region typed memory (type bit = 0) is valid only while command enable bit 1 is set.
- R3: The reported base is the register value with its low log2(size) bits cleared. Whenever the valid flag is low, the reported base is zero.
- R4: A region whose aligned base is zero decodes as unmapped.
- R5: A region whose last address (base + size − 1, modulo 2^32) is not greater than its base decodes as unmapped. A size of one is such a case.
- R6: An I/O region whose last address is 0x10000 or above decodes as unmapped.
- R7: A memory region whose last address is 0xFFFFFFFF decodes as unmapped.
- R8: When region 6 (the expansion ROM) is typed memory, it is valid only while bit 0 of its register value is set. That bit is not part of the reported base.
- R9: Outputs are registered. A window decoded from the inputs present at a rising edge appears after that edge. A synchronous active-low reset clears every valid flag, base and change pulse.
- R10: A region's change output is high for exactly the cycle in which its valid flag or base differs from the value shown in the previous cycle. It is low while the window holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_enables | input | 2 | Bit 0: I/O space enable, bit 1: memory space enable |
| bar_values | input | 7*32 | Stored register value of region n at bits [32n +: 32], region 6 is the ROM |
| bar_sizes | input | 7*32 | Power-of-two size of region n at bits [32n +: 32], zero = not implemented |
| bar_is_io | input | 7 | Bit n: 1 = region n claims I/O space, 0 = memory space |
| win_valid | output | 7 | Bit n: region n has a mapped window |
| win_base | output | 7*32 | Aligned base of region n at bits [32n +: 32], zero when unmapped |
| win_changed | output | 7 | Bit n pulses when region n's window differs from the previous cycle |

## Verification
The bench aims at the edges of every invalidation rule. A size of one must fail the wrap test, and a design that compared with greater-or-equal would map it. The I/O window ending exactly at 0xFFFF must stay valid while the one starting at 0x10000 is dropped, which separates an off-by-one limit. A memory window ending at all ones must be rejected while its neighbour one window lower is accepted. A ROM with bit 0 clear must stay unmapped, and a design ignoring that bit would map it, or one keeping the bit in the base would report an odd address. A sweep over every size from 1 to 64 KiB, all four enable combinations and mixed register patterns compares each region against an arithmetic model. It also checks that the change pulse follows exactly the model's window transitions, so a design that pulsed on every input change, or held the pulse, is caught.

// File: rtl/bawd_pkg.sv
// Package: shared constants and types for the base address window decoder.
// Assumes the command enables arrive as a two-bit vector with the I/O enable
// in bit 0 and the memory enable in bit 1.
package bawd_pkg;

    // Positions of the space enables inside cmd_enables.
    localparam int unsigned CMD_IO_BIT  = 0;
    localparam int unsigned CMD_MEM_BIT = 1;

    // Address space a region claims.
    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    // Reason a region ended up unmapped; internal use for readability.
    typedef enum logic [2:0] {
        WIN_OK       = 3'd0,
        WIN_NO_SIZE  = 3'd1,
        WIN_DISABLED = 3'd2,
        WIN_ROM_OFF  = 3'd3,
        WIN_ZERO     = 3'd4,
        WIN_WRAP     = 3'd5,
        WIN_RANGE    = 3'd6
    } win_status_e;

endpackage

// File: rtl/bawd_region_decode.sv
// Module: combinational decode of one address region.
// Aligns the register value to the region size and applies the enable and
// invalidation rules. Assumes the size is zero or a power of two; a size
// that is neither gives an undefined alignment. IS_ROM selects the variant
// that also requires bit 0 of the register value when typed memory.
module bawd_region_decode
    import bawd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IO_LIMIT = 32'h0001_0000,
    parameter bit          IS_ROM   = 1'b0
) (
    input  logic [ADDR_W-1:0] reg_value,
    input  logic [ADDR_W-1:0] size,
    input  logic              is_io,
    input  logic [1:0]        cmd_enables,
    output logic              valid,
    output logic [ADDR_W-1:0] base
);

    localparam logic [ADDR_W-1:0] IO_LIM   = ADDR_W'(IO_LIMIT);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] last_addr;
    space_e            space;
    logic              space_on;
    logic              rom_gate;
    win_status_e       status;

    // Alignment mask and window bounds.
    always_comb begin
        size_mask = ~(size - ADDR_W'(1));
        aligned   = reg_value & size_mask;
        last_addr = aligned + size - ADDR_W'(1);
    end

    // Space enable and ROM enable gating.
    always_comb begin
        space    = is_io ? SPACE_IO : SPACE_MEM;
        space_on = (space == SPACE_IO) ? cmd_enables[CMD_IO_BIT]
                                       : cmd_enables[CMD_MEM_BIT];
        if (IS_ROM && space == SPACE_MEM) begin
            rom_gate = reg_value[0];
        end else begin
            rom_gate = 1'b1;
        end
    end

    // Priority of the invalidation rules; the first failing rule wins.
    always_comb begin
        if (size == '0) begin
            status = WIN_NO_SIZE;
        end else if (!space_on) begin
            status = WIN_DISABLED;
        end else if (!rom_gate) begin
            status = WIN_ROM_OFF;
        end else if (aligned == '0) begin
            status = WIN_ZERO;
        end else if (last_addr <= aligned) begin
            status = WIN_WRAP;
        end else if (space == SPACE_IO && last_addr >= IO_LIM) begin
            status = WIN_RANGE;
        end else if (space == SPACE_MEM && last_addr == ALL_ONES) begin
            status = WIN_RANGE;
        end else begin
            status = WIN_OK;
        end
    end

    // Report the window; an unmapped region shows base zero.
    always_comb begin
        valid = (status == WIN_OK);
        base  = valid ? aligned : '0;
    end

endmodule

// File: rtl/bawd_window_track.sv
// Module: holds the decoded windows of all regions and flags transitions.
// Each region's valid flag and base are registered every cycle; the change
// bit is registered alongside and is high only in the cycle the stored
// window first shows a new value. Synchronous active-low reset.
module bawd_window_track #(
    parameter int unsigned NREG   = 7,
    parameter int unsigned ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        next_valid,
    input  logic [NREG*ADDR_W-1:0] next_base,
    output logic [NREG-1:0]        cur_valid,
    output logic [NREG*ADDR_W-1:0] cur_base,
    output logic [NREG-1:0]        changed
);

    logic [NREG-1:0] differs;

    // Per-region comparison of the new decode against the stored window.
    for (genvar n = 0; n < NREG; n++) begin : g_cmp
        always_comb begin
            differs[n] = (next_valid[n] != cur_valid[n]) ||
                         (next_base[n*ADDR_W +: ADDR_W] != cur_base[n*ADDR_W +: ADDR_W]);
        end
    end

    // Window and change registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= '0;
            cur_base  <= '0;
            changed   <= '0;
        end else begin
            cur_valid <= next_valid;
            cur_base  <= next_base;
            changed   <= differs;
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
// Module: top of the base address window decoder.
// Decodes NUM_BARS base regions plus one expansion-ROM region (the last
// index) from packed register values, sizes and space types, then registers
// the result with per-region change pulses. Assumes every size input is zero
// or a power of two and stays stable while the caller relies on the window.
module bar_window_decoder #(
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          cmd_enables,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]      bar_values,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]      bar_sizes,
    input  logic [NUM_BARS:0]                   bar_is_io,
    output logic [NUM_BARS:0]                   win_valid,
    output logic [(NUM_BARS+1)*ADDR_W-1:0]      win_base,
    output logic [NUM_BARS:0]                   win_changed
);

    localparam int unsigned NREG    = NUM_BARS + 1;
    localparam int unsigned ROM_IDX = NUM_BARS;

    logic [NREG-1:0]        dec_valid;
    logic [NREG*ADDR_W-1:0] dec_base;

    // One decoder per region; the last one is the ROM variant.
    for (genvar n = 0; n < NREG; n++) begin : g_region
        bawd_region_decode #(
            .ADDR_W   (ADDR_W),
            .IO_LIMIT (IO_LIMIT),
            .IS_ROM   (n == ROM_IDX)
        ) u_dec (
            .reg_value   (bar_values[n*ADDR_W +: ADDR_W]),
            .size        (bar_sizes[n*ADDR_W +: ADDR_W]),
            .is_io       (bar_is_io[n]),
            .cmd_enables (cmd_enables),
            .valid       (dec_valid[n]),
            .base        (dec_base[n*ADDR_W +: ADDR_W])
        );
    end

    bawd_window_track #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_valid (dec_valid),
        .next_base  (dec_base),
        .cur_valid  (win_valid),
        .cur_base   (win_base),
        .changed    (win_changed)
    );

endmodule

// File: rtl/bawd_checker.sv
// Module: assertion checker for bar_window_decoder, attached by bind.
// Relates each registered window to the inputs of the previous cycle and
// to the window shown one cycle earlier.
module bawd_checker #(
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [1:0]                     cmd_enables,
    input logic [(NUM_BARS+1)*ADDR_W-1:0] bar_values,
    input logic [(NUM_BARS+1)*ADDR_W-1:0] bar_sizes,
    input logic [NUM_BARS:0]              bar_is_io,
    input logic [NUM_BARS:0]              win_valid,
    input logic [(NUM_BARS+1)*ADDR_W-1:0] win_base,
    input logic [NUM_BARS:0]              win_changed
);

    localparam int unsigned NREG = NUM_BARS + 1;
    localparam logic [ADDR_W-1:0] IO_LIM = ADDR_W'(IO_LIMIT);

    logic run_q;

    // Marks that the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        run_q <= rst_n;
    end

    for (genvar n = 0; n < NREG; n++) begin : g_chk
        AST_ZERO_SIZE_NEVER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && $past(bar_sizes[n*ADDR_W +: ADDR_W]) == '0) |-> !win_valid[n]); // R1

        AST_SPACE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && win_valid[n]) |->
                ($past(bar_is_io[n]) ? $past(cmd_enables[0]) : $past(cmd_enables[1]))); // R2

        AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && win_valid[n]) |->
                ((win_base[n*ADDR_W +: ADDR_W] &
                  ($past(bar_sizes[n*ADDR_W +: ADDR_W]) - ADDR_W'(1))) == '0)); // R3

        AST_UNMAPPED_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !win_valid[n] |-> win_base[n*ADDR_W +: ADDR_W] == '0); // R3

        AST_VALID_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid[n] |-> win_base[n*ADDR_W +: ADDR_W] != '0); // R4

        AST_IO_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && win_valid[n] && $past(bar_is_io[n])) |->
                (win_base[n*ADDR_W +: ADDR_W] +
                 $past(bar_sizes[n*ADDR_W +: ADDR_W]) - ADDR_W'(1)) < IO_LIM); // R6

        AST_CHANGE_TRACKS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> (win_changed[n] ==
                (($past(win_valid[n]) != win_valid[n]) ||
                 ($past(win_base[n*ADDR_W +: ADDR_W]) != win_base[n*ADDR_W +: ADDR_W])))); // R10
    end

    AST_ROM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && win_valid[NUM_BARS] && !$past(bar_is_io[NUM_BARS])) |->
            $past(bar_values[NUM_BARS*ADDR_W])); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (rst_n && !run_q) |-> (win_valid == '0 && win_changed == '0)); // R9

endmodule

bind bar_window_decoder bawd_checker #(
    .NUM_BARS (NUM_BARS),
    .ADDR_W   (ADDR_W),
    .IO_LIMIT (IO_LIMIT)
) u_bawd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_enables (cmd_enables),
    .bar_values  (bar_values),
    .bar_sizes   (bar_sizes),
    .bar_is_io   (bar_is_io),
    .win_valid   (win_valid),
    .win_base    (win_base),
    .win_changed (win_changed)
);

// File: tb/sim_bar_window_decoder.sv
// Bench: directed corner cases and a sweep against an arithmetic model.
module sim_bar_window_decoder;

    localparam int NB = 6;
    localparam int NR = NB + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd_enables = 2'b00;
    logic [NR*32-1:0]  bar_values;
    logic [NR*32-1:0]  bar_sizes;
    logic [NR-1:0]     bar_is_io;
    logic [NR-1:0]     win_valid;
    logic [NR*32-1:0]  win_base;
    logic [NR-1:0]     win_changed;

    logic [31:0] rv [NR];
    logic [31:0] sz [NR];
    logic        io [NR];
    logic        pv [NR];
    logic [31:0] pb [NR];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Pack the per-region stimulus arrays onto the ports.
    always_comb begin
        for (int n = 0; n < NR; n++) begin
            bar_values[n*32 +: 32] = rv[n];
            bar_sizes[n*32 +: 32]  = sz[n];
            bar_is_io[n]           = io[n];
        end
    end

    bar_window_decoder u0 (
        .clk (clk), .rst_n (rst_n), .cmd_enables (cmd_enables),
        .bar_values (bar_values), .bar_sizes (bar_sizes), .bar_is_io (bar_is_io),
        .win_valid (win_valid), .win_base (win_base), .win_changed (win_changed)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected window from the requirement list.
    task automatic model(input logic [31:0] r, input logic [31:0] s, input logic isio,
                         input logic rom, input logic [1:0] cmd,
                         output logic v, output logic [31:0] b);
        logic [31:0] al;
        logic [31:0] last;
        al   = r & ~(s - 32'd1);
        last = al + s - 32'd1;
        v = (s != 0);                                   // R1
        v = v && (isio ? cmd[0] : cmd[1]);              // R2
        v = v && (!rom || isio || r[0]);                // R8
        v = v && (al != 0);                             // R4
        v = v && (last > al);                           // R5
        v = v && (isio ? (last < 32'h10000) : (last != 32'hFFFF_FFFF)); // R6 R7
        b = v ? al : 32'h0;                             // R3
    endtask

    // Apply the stimulus one edge, then compare every region and its change bit.
    task automatic step_and_check(input string tag);
        logic       ev;
        logic [31:0] eb;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < NR; n++) begin
            model(rv[n], sz[n], io[n], n == NB, cmd_enables, ev, eb);
            check({tag, " R2 R4 R5 R6 R7 R8 valid"}, {31'b0, win_valid[n]}, {31'b0, ev});
            check({tag, " R3 base"}, win_base[n*32 +: 32], eb);
            check({tag, " R10 change"}, {31'b0, win_changed[n]},
                  {31'b0, (ev != pv[n]) || (eb != pb[n])});
            pv[n] = ev;
            pb[n] = eb;
        end
    endtask

    task automatic set_all_off();
        for (int n = 0; n < NR; n++) begin
            rv[n] = 32'h0; sz[n] = 32'h0; io[n] = 1'b0;
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'h0000_FF01; pats[2] = 32'h1234_5679;
        pats[3] = 32'hFFFF_FFF1; pats[4] = 32'h0000_8000; pats[5] = 32'hC000_0001;

        set_all_off();
        for (int n = 0; n < NR; n++) begin pv[n] = 1'b0; pb[n] = 32'h0; end
        rv[0] = 32'h1000; sz[0] = 32'h100; cmd_enables = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset holds everything cleared even with a mappable input.
        check("R9 reset valid", {25'b0, win_valid}, 32'h0);
        check("R9 reset base0", win_base[31:0], 32'h0);
        check("R9 reset change", {25'b0, win_changed}, 32'h0);
        rst_n = 1'b1;
        set_all_off();
        step_and_check("R9 idle");

        // R1: unimplemented region stays unmapped.
        rv[0] = 32'h0000_1000; sz[0] = 32'h0; io[0] = 1'b0;
        step_and_check("R1 zero size");
        check("R1 explicit", {31'b0, win_valid[0]}, 32'h0);

        // R2: I/O region gated by enable bit 0.
        rv[0] = 32'h0000_0100; sz[0] = 32'h10; io[0] = 1'b1; cmd_enables = 2'b10;
        step_and_check("R2 io off");
        check("R2 io off explicit", {31'b0, win_valid[0]}, 32'h0);
        cmd_enables = 2'b01;
        step_and_check("R2 io on");
        check("R2 io on explicit", win_base[31:0], 32'h0000_0100);
        check("R10 pulse on map", {31'b0, win_changed[0]}, 32'h1);
        step_and_check("R10 steady");
        check("R10 pulse drops", {31'b0, win_changed[0]}, 32'h0);

        // R3: alignment of a memory window.
        rv[1] = 32'h1234_5678; sz[1] = 32'h1000; io[1] = 1'b0; cmd_enables = 2'b10;
        step_and_check("R3 align");
        check("R3 explicit", win_base[63:32], 32'h1234_5000);

        // R4: base rounds down to zero.
        rv[1] = 32'h0000_0FFF;
        step_and_check("R4 zero base");
        check("R4 explicit", {31'b0, win_valid[1]}, 32'h0);

        // R5: size one never passes the wrap test.
        rv[1] = 32'h0000_4000; sz[1] = 32'h1;
        step_and_check("R5 size one");
        check("R5 explicit", {31'b0, win_valid[1]}, 32'h0);

        // R6: I/O window at the 64 KiB edge.
        cmd_enables = 2'b11;
        rv[2] = 32'h0000_FF00; sz[2] = 32'h100; io[2] = 1'b1;
        step_and_check("R6 io top");
        check("R6 top ok", {31'b0, win_valid[2]}, 32'h1);
        rv[2] = 32'h0001_0000;
        step_and_check("R6 io over");
        check("R6 over explicit", {31'b0, win_valid[2]}, 32'h0);

        // R7: memory window ending at all ones.
        rv[3] = 32'hFFFF_F000; sz[3] = 32'h1000; io[3] = 1'b0;
        step_and_check("R7 top");
        check("R7 explicit", {31'b0, win_valid[3]}, 32'h0);
        rv[3] = 32'hFFFF_E000;
        step_and_check("R7 below top");
        check("R7 below ok", win_base[127:96], 32'hFFFF_E000);

        // R8: ROM enable bit.
        rv[NB] = 32'hC000_0000; sz[NB] = 32'h10000; io[NB] = 1'b0;
        step_and_check("R8 rom off");
        check("R8 off explicit", {31'b0, win_valid[NB]}, 32'h0);
        rv[NB] = 32'hC000_0001;
        step_and_check("R8 rom on");
        check("R8 on explicit", win_base[NB*32 +: 32], 32'hC000_0000);

        // Sweep: sizes 0 and 1..64 KiB, every enable pair, rotated patterns.
        for (int k = -1; k <= 16; k++) begin
            for (int c = 0; c < 4; c++) begin
                for (int p = 0; p < 6; p++) begin
                    cmd_enables = 2'(c);
                    for (int n = 0; n < NR; n++) begin
                        rv[n] = pats[(p + n) % 6] ^ (32'(k + 1) << 4);
                        sz[n] = (k < 0) ? 32'h0 : (32'h1 << k);
                        io[n] = ((n + p) % 2) == 1;
                    end
                    step_and_check("sweep R1 R2 R3 R10");
                end
            end
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule